// File: doc/BRIEF.md
# Debug Hart Handshake Controller

This block is the debugger-side half of a shared-memory mailbox. Halted harts spin in a fixed debug loop and talk to it only through loads and stores on a small slave window. That window holds three parts. The first is one flag byte per hart, which the harts poll. The second is a set of write-only notification addresses, where a hart reports that it is halted, that it has picked up a go order, that it is resuming, or that its debug program trapped. The third is a one-word jump slot, which the loop jumps through once it is released.

On the other side, a command port accepts three kinds of request. The first runs the abstract-command code on one halted hart. The second runs the program buffer on one halted hart. The third resumes a set of harts. For every request the controller first rewrites the jump slot with a `jal x0` instruction that points at the right entry. Only after that does it raise the flag bits. It then follows the harts' acknowledgement stores until the command ends. The debugger sees busy, a done pulse, an exception indication and the halted state of each hart.

Top module: `dbg_handshake_ctrl`

## Requirements
- R1: After reset, every flag byte reads 0, the halted vector is 0, busy and done are 0, exc is 0, and the jump slot reads 0.
- R2: A read at FLAG_BASE+h (default 0x400+h) for a hart h below NUM_HARTS returns that hart's flag byte zero-extended on bus_rdata. Bit 0 of the byte is GO and bit 1 is RESUME. A read at any unmapped address returns 0.
- R3: A store to the HALTED address (0x100) sets the halted bit of the hart whose ID is in bus_wdata, and repeating the store keeps the bit set. A store whose ID is not below NUM_HARTS changes nothing.
- R4: A command is accepted (cmd_accept high in the same cycle) only while the controller is idle. After the accepting edge, busy is 1 and the jump slot already holds the new instruction. For a go command, GO of the chosen hart rises one edge later.
- R5: At most one GO bit is set at any time. A go command (cmd_kind 0 = abstract, 1 = program buffer) is refused if the target hart is not halted.
- R6: Any store to the GOING address (0x104) clears the GO bit of the hart that was told to go, and the command then waits for completion.
- R7: While the command waits for completion, a HALTED store carrying the selected hart's ID ends the command. done pulses for one cycle, busy falls, and exc stays 0. A HALTED store from any other hart does not end the command.
- R8: A store to the EXCEPTION address (0x10C) while a go command is waiting ends that command. done pulses, exc becomes 1, and GO is cleared. exc holds until the next command is accepted.
- R9: A resume command (cmd_kind 2) sets RESUME for every hart that is both in cmd_resume_mask and halted. It finishes one edge after acceptance with a done pulse. Any number of harts may hold RESUME at once. cmd_kind 3 is always refused.
- R10: A store of a hart ID to the RESUMING address (0x108) clears that hart's RESUME bit and its halted bit. A store with an out-of-range ID changes nothing.
- R11: Requests of every kind are refused while busy is 1.
- R12: The jump slot (0x300) holds a `jal x0` to the chosen entry, with the offset measured from the slot address. With the default entries the slot reads 0x0400006F for abstract (0x340), 0x0600006F for program buffer (0x360) and 0x5080006F for resume (0x808).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wdata | input | 32 | Store data (hart ID for notifications) |
| bus_rdata | output | 32 | Load data, combinational from bus_addr |
| cmd_valid | input | 1 | Debugger request valid |
| cmd_kind | input | 2 | 0 abstract, 1 program buffer, 2 resume, 3 illegal |
| cmd_hart | input | HART_W | Target hart for go commands |
| cmd_resume_mask | input | NUM_HARTS | Harts to resume |
| cmd_accept | output | 1 | Request taken this cycle |
| busy | output | 1 | A command is in flight |
| done | output | 1 | One-cycle pulse when a command ends |
| exc | output | 1 | Last command ended in an exception |
| halted | output | NUM_HARTS | Halted status per hart |

## Verification
The bench targets the ordering hazards of the mailbox. It checks that the jump slot is already rewritten in the cycle before GO becomes visible. A design that raised GO first would send a hart through a stale instruction. It also checks that a HALTED store from a bystander hart does not end a waiting command, while the selected hart's store does. A design that compared the wrong ID would finish early or hang. The bench confirms that out-of-range IDs on HALTED and RESUMING stores leave flags and halted state alone, that resume skips harts that are not halted, and that every kind of request is refused mid-command. The exception path is checked for a sticky exc bit that clears only on the next acceptance.

// File: rtl/dbg_hs_pkg.sv
// Package: shared types, window map and the jump-instruction builder for
// the debug hart handshake controller. Assumes a 32-bit data path.
package dbg_hs_pkg;

    typedef enum logic [1:0] {
        CMD_ABSTRACT = 2'd0,
        CMD_PROGBUF  = 2'd1,
        CMD_RESUME   = 2'd2,
        CMD_ILLEGAL  = 2'd3
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP_SLOT,
        ST_WAIT_GOING,
        ST_WAIT_DONE
    } hs_state_e;

    localparam int ADDR_HALTED    = 'h100;
    localparam int ADDR_GOING     = 'h104;
    localparam int ADDR_RESUMING  = 'h108;
    localparam int ADDR_EXCEPTION = 'h10C;
    localparam int ADDR_SLOT      = 'h300;
    localparam int FLAG_BASE      = 'h400;

    localparam int FLAG_GO_BIT     = 0;
    localparam int FLAG_RESUME_BIT = 1;

    // Builds "jal x0, off" from a 21-bit signed byte offset.
    function automatic logic [31:0] jal_x0(input logic [20:0] off);
        return {off[20], off[10:1], off[11], off[19:12], 5'd0, 7'h6F};
    endfunction

endpackage

// File: rtl/dbg_hs_decode.sv
// Module: bus decoder. Turns a store on the window into one-cycle
// notification strobes and extracts the hart ID carried in the data.
// Also resolves which flag byte or the slot a load points at.
// Assumes one access per cycle; loads have no side effects.
module dbg_hs_decode
    import dbg_hs_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int ADDR_W    = 12,
    localparam int HART_W   = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              halted_we,
    output logic              going_we,
    output logic              resuming_we,
    output logic              exc_we,
    output logic [HART_W-1:0] id,
    output logic              id_ok,
    output logic              rd_flag_hit,
    output logic [HART_W-1:0] rd_flag_idx,
    output logic              rd_slot_hit
);

    logic st;
    logic ld;
    int   addr_i;

    // Store/load qualifiers and the address as an integer.
    always_comb begin
        st     = bus_req && bus_we;
        ld     = bus_req && !bus_we;
        addr_i = int'(bus_addr);
    end

    // Notification strobes and the hart ID carried in the data.
    always_comb begin
        halted_we   = st && (addr_i == ADDR_HALTED);
        going_we    = st && (addr_i == ADDR_GOING);
        resuming_we = st && (addr_i == ADDR_RESUMING);
        exc_we      = st && (addr_i == ADDR_EXCEPTION);
        id          = bus_wdata[HART_W-1:0];
        id_ok       = (bus_wdata < 32'(NUM_HARTS));
    end

    // Load target resolution for the read mux.
    always_comb begin
        rd_slot_hit = ld && (addr_i == ADDR_SLOT);
        rd_flag_hit = ld && (addr_i >= FLAG_BASE) && (addr_i < FLAG_BASE + NUM_HARTS);
        rd_flag_idx = HART_W'(addr_i - FLAG_BASE);
    end

endmodule

// File: rtl/dbg_hs_hart_state.sv
// Module: per-hart mailbox state. For each hart it holds the GO flag, the
// RESUME flag and the halted status, which the command FSM and the harts'
// acknowledgement stores update. Assumes the FSM raises go_set for at most
// one hart, and only while no GO is pending.
module dbg_hs_hart_state #(
    parameter int NUM_HARTS = 4,
    localparam int HART_W   = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 halted_we,
    input  logic                 resuming_we,
    input  logic [HART_W-1:0]    id,
    input  logic                 id_ok,
    input  logic                 go_set,
    input  logic                 go_clr,
    input  logic [HART_W-1:0]    go_hart,
    input  logic [NUM_HARTS-1:0] resume_set,
    output logic [NUM_HARTS-1:0] go_q,
    output logic [NUM_HARTS-1:0] resume_q,
    output logic [NUM_HARTS-1:0] halted_q
);

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        logic mine;
        logic told;

        // Decode whether the current store and the GO target address this hart.
        always_comb begin
            mine = id_ok && (int'(id) == h);
            told = (int'(go_hart) == h);
        end

        // GO: a set from the FSM has priority over a clear in the same cycle.
        always_ff @(posedge clk) begin
            if (!rst_n)                 go_q[h] <= 1'b0;
            else if (go_set && told)    go_q[h] <= 1'b1;
            else if (go_clr && told)    go_q[h] <= 1'b0;
        end

        // RESUME: set by a resume command, cleared by that hart's ack.
        always_ff @(posedge clk) begin
            if (!rst_n)                     resume_q[h] <= 1'b0;
            else if (resume_set[h])         resume_q[h] <= 1'b1;
            else if (resuming_we && mine)   resume_q[h] <= 1'b0;
        end

        // Halted: relearned from every loop store, dropped on the resume ack.
        always_ff @(posedge clk) begin
            if (!rst_n)                     halted_q[h] <= 1'b0;
            else if (halted_we && mine)     halted_q[h] <= 1'b1;
            else if (resuming_we && mine)   halted_q[h] <= 1'b0;
        end
    end

    // R5
    one_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(go_q));

    // R3
    halted_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_we && id_ok) |=> halted_q[$past(id)]);

    // R10
    resuming_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resuming_we && id_ok) |=> (!halted_q[$past(id)] && !resume_q[$past(id)]));

endmodule

// File: rtl/dbg_hs_cmd_fsm.sv
// Module: command sequencer. It accepts one debugger request at a time,
// rewrites the jump slot, then raises GO or RESUME and follows the harts'
// acknowledgements until the command ends. Assumes the slot instruction
// words are constant (computed by the top from its parameters).
module dbg_hs_cmd_fsm
    import dbg_hs_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    localparam int HART_W   = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_kind,
    input  logic [HART_W-1:0]    cmd_hart,
    input  logic [NUM_HARTS-1:0] cmd_resume_mask,
    input  logic [31:0]          jal_abstract,
    input  logic [31:0]          jal_progbuf,
    input  logic [31:0]          jal_resume,
    input  logic [NUM_HARTS-1:0] halted_q,
    input  logic                 halted_we,
    input  logic                 going_we,
    input  logic                 exc_we,
    input  logic [HART_W-1:0]    id,
    input  logic                 id_ok,
    output logic                 cmd_accept,
    output logic                 busy,
    output logic                 done,
    output logic                 exc,
    output logic                 go_set,
    output logic                 go_clr,
    output logic [HART_W-1:0]    sel_hart,
    output logic [NUM_HARTS-1:0] resume_set,
    output logic [31:0]          slot_q
);

    hs_state_e            state_q, state_d;
    cmd_kind_e            kind_q;
    logic [NUM_HARTS-1:0] mask_q;
    logic                 legal;
    logic                 waiting;
    logic                 fin;
    logic                 fin_exc;
    logic [31:0]          slot_new;

    // Legality of the offered request and the slot word it needs.
    always_comb begin
        unique case (cmd_kind_e'(cmd_kind))
            CMD_ABSTRACT: begin
                legal    = (int'(cmd_hart) < NUM_HARTS) && halted_q[cmd_hart];
                slot_new = jal_abstract;
            end
            CMD_PROGBUF: begin
                legal    = (int'(cmd_hart) < NUM_HARTS) && halted_q[cmd_hart];
                slot_new = jal_progbuf;
            end
            CMD_RESUME: begin
                legal    = 1'b1;
                slot_new = jal_resume;
            end
            default: begin
                legal    = 1'b0;
                slot_new = jal_resume;
            end
        endcase
        cmd_accept = cmd_valid && legal && (state_q == ST_IDLE);
        busy       = (state_q != ST_IDLE);
    end

    // Next state, flag requests and end-of-command detection.
    always_comb begin
        state_d    = state_q;
        go_set     = 1'b0;
        resume_set = '0;
        fin        = 1'b0;
        fin_exc    = 1'b0;
        waiting    = (state_q == ST_WAIT_GOING) || (state_q == ST_WAIT_DONE);
        go_clr     = going_we || (exc_we && waiting);
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_accept) state_d = ST_SETUP_SLOT;
            end
            ST_SETUP_SLOT: begin
                if (kind_q == CMD_RESUME) begin
                    resume_set = mask_q & halted_q;
                    fin        = 1'b1;
                    state_d    = ST_IDLE;
                end else begin
                    go_set  = 1'b1;
                    state_d = ST_WAIT_GOING;
                end
            end
            ST_WAIT_GOING: begin
                if (exc_we) begin
                    fin     = 1'b1;
                    fin_exc = 1'b1;
                    state_d = ST_IDLE;
                end else if (going_we) begin
                    state_d = ST_WAIT_DONE;
                end
            end
            ST_WAIT_DONE: begin
                if (exc_we) begin
                    fin     = 1'b1;
                    fin_exc = 1'b1;
                    state_d = ST_IDLE;
                end else if (halted_we && id_ok && (id == sel_hart)) begin
                    fin     = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Latch the accepted request and rewrite the jump slot at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q   <= CMD_RESUME;
            mask_q   <= '0;
            sel_hart <= '0;
            slot_q   <= '0;
        end else if (cmd_accept) begin
            kind_q   <= cmd_kind_e'(cmd_kind);
            mask_q   <= cmd_resume_mask;
            sel_hart <= cmd_hart;
            slot_q   <= slot_new;
        end
    end

    // Done pulse and sticky exception indication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            exc  <= 1'b0;
        end else begin
            done <= fin;
            if (cmd_accept) exc <= 1'b0;
            else if (fin_exc) exc <= 1'b1;
        end
    end

    // R4
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_accept |=> (busy && !done));

    // R11
    refuse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |-> !cmd_accept);

    // R8
    exc_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_we && waiting) |=> (done && exc && !busy));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/dbg_handshake_ctrl.sv
// Module: top of the debug hart handshake controller. It connects the bus
// decoder, the per-hart mailbox state and the command sequencer, builds
// the three slot instructions from the entry parameters, and muxes load
// data. Assumes entries lie within +/-1 MiB of the slot.
module dbg_handshake_ctrl
    import dbg_hs_pkg::*;
#(
    parameter int NUM_HARTS      = 4,
    parameter int ADDR_W         = 12,
    parameter int ABSTRACT_ENTRY = 'h340,
    parameter int PROGBUF_ENTRY  = 'h360,
    parameter int RESUME_ENTRY   = 'h808,
    localparam int HART_W        = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_kind,
    input  logic [HART_W-1:0]    cmd_hart,
    input  logic [NUM_HARTS-1:0] cmd_resume_mask,
    output logic                 cmd_accept,
    output logic                 busy,
    output logic                 done,
    output logic                 exc,
    output logic [NUM_HARTS-1:0] halted
);

    localparam logic [20:0] OFF_ABS = 21'(ABSTRACT_ENTRY - ADDR_SLOT);
    localparam logic [20:0] OFF_PB  = 21'(PROGBUF_ENTRY - ADDR_SLOT);
    localparam logic [20:0] OFF_RES = 21'(RESUME_ENTRY - ADDR_SLOT);

    logic                 halted_we, going_we, resuming_we, exc_we;
    logic [HART_W-1:0]    id;
    logic                 id_ok;
    logic                 rd_flag_hit, rd_slot_hit;
    logic [HART_W-1:0]    rd_flag_idx;
    logic                 go_set, go_clr;
    logic [HART_W-1:0]    sel_hart;
    logic [NUM_HARTS-1:0] resume_set;
    logic [NUM_HARTS-1:0] go_q, resume_q, halted_q;
    logic [31:0]          slot_q;
    logic [31:0]          jal_abs, jal_pb, jal_res;

    // Constant slot instruction words.
    always_comb begin
        jal_abs = jal_x0(OFF_ABS);
        jal_pb  = jal_x0(OFF_PB);
        jal_res = jal_x0(OFF_RES);
    end

    dbg_hs_decode #(.NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W)) u_decode (
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .halted_we   (halted_we),
        .going_we    (going_we),
        .resuming_we (resuming_we),
        .exc_we      (exc_we),
        .id          (id),
        .id_ok       (id_ok),
        .rd_flag_hit (rd_flag_hit),
        .rd_flag_idx (rd_flag_idx),
        .rd_slot_hit (rd_slot_hit)
    );

    dbg_hs_hart_state #(.NUM_HARTS(NUM_HARTS)) u_harts (
        .clk         (clk),
        .rst_n       (rst_n),
        .halted_we   (halted_we),
        .resuming_we (resuming_we),
        .id          (id),
        .id_ok       (id_ok),
        .go_set      (go_set),
        .go_clr      (go_clr),
        .go_hart     (sel_hart),
        .resume_set  (resume_set),
        .go_q        (go_q),
        .resume_q    (resume_q),
        .halted_q    (halted_q)
    );

    dbg_hs_cmd_fsm #(.NUM_HARTS(NUM_HARTS)) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .cmd_valid       (cmd_valid),
        .cmd_kind        (cmd_kind),
        .cmd_hart        (cmd_hart),
        .cmd_resume_mask (cmd_resume_mask),
        .jal_abstract    (jal_abs),
        .jal_progbuf     (jal_pb),
        .jal_resume      (jal_res),
        .halted_q        (halted_q),
        .halted_we       (halted_we),
        .going_we        (going_we),
        .exc_we          (exc_we),
        .id              (id),
        .id_ok           (id_ok),
        .cmd_accept      (cmd_accept),
        .busy            (busy),
        .done            (done),
        .exc             (exc),
        .go_set          (go_set),
        .go_clr          (go_clr),
        .sel_hart        (sel_hart),
        .resume_set      (resume_set),
        .slot_q          (slot_q)
    );

    // Load data mux: flag byte, slot word or zero.
    always_comb begin
        bus_rdata = '0;
        if (rd_slot_hit) begin
            bus_rdata = slot_q;
        end else if (rd_flag_hit) begin
            bus_rdata[FLAG_GO_BIT]     = go_q[rd_flag_idx];
            bus_rdata[FLAG_RESUME_BIT] = resume_q[rd_flag_idx];
        end
        halted = halted_q;
    end

    // R6
    going_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (going_we && !go_set) |=> (go_q == '0));

    // R9
    resume_only_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_set != '0) |-> ((resume_set & ~halted_q) == '0));

endmodule

// File: tb/dbg_handshake_ctrl_tb.sv
module dbg_handshake_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_kind = '0;
    logic [1:0]  cmd_hart = '0;
    logic [3:0]  cmd_resume_mask = '0;
    logic        cmd_accept, busy, done, exc;
    logic [3:0]  halted;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    dbg_handshake_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_hart(cmd_hart),
        .cmd_resume_mask(cmd_resume_mask), .cmd_accept(cmd_accept),
        .busy(busy), .done(done), .exc(exc), .halted(halted)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_store(input int addr, input int data);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'(addr); bus_wdata = 32'(data);
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_load(input int addr, output logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 12'(addr);
        #1 d = bus_rdata;
        bus_req = 1'b0;
    endtask

    task automatic chk_flag(input int h, input logic [31:0] exp, input string tag);
        logic [31:0] d;
        bus_load('h400 + h, d);
        chk(d, exp, tag);
    endtask

    task automatic issue(input logic [1:0] k, input logic [1:0] h, input logic [3:0] m,
                         output logic acc);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = k; cmd_hart = h; cmd_resume_mask = m;
        #1 acc = cmd_accept;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        @(negedge clk);
        chk({28'd0, halted}, 0, "R1 halted");
        chk({29'd0, busy, done, exc}, 0, "R1 busy/done/exc");
        for (int h = 0; h < 4; h++) chk_flag(h, 0, "R1 flag");
        bus_load('h300, d); chk(d, 0, "R1 slot");
        bus_load('h200, d); chk(d, 0, "R2 unmapped read");
    endtask

    task automatic t_halted();
        bus_store('h100, 0);
        bus_store('h100, 2);
        bus_store('h100, 2);
        chk({28'd0, halted}, 4'b0101, "R3 halted set/keep");
        bus_store('h100, 7);
        bus_store('h100, 4);
        chk({28'd0, halted}, 4'b0101, "R3 out-of-range ignored");
    endtask

    task automatic t_refuse_not_halted();
        logic acc;
        issue(2'd0, 2'd1, 4'd0, acc);
        chk({31'd0, acc}, 0, "R5 refuse non-halted");
        chk({31'd0, busy}, 0, "R5 stays idle");
        issue(2'd3, 2'd0, 4'd0, acc);
        chk({31'd0, acc}, 0, "R9 illegal kind refused");
    endtask

    task automatic t_abstract();
        logic acc;
        logic [31:0] d;
        issue(2'd0, 2'd2, 4'd0, acc);
        chk({31'd0, acc}, 1, "R4 accept");
        chk({31'd0, busy}, 1, "R4 busy");
        bus_load('h300, d); chk(d, 32'h0400006F, "R12 abstract jal");
        chk_flag(2, 0, "R4 GO not before slot");
        @(negedge clk);
        chk_flag(2, 1, "R2 GO bit0 set");
        chk_flag(0, 0, "R5 single GO");
        issue(2'd1, 2'd0, 4'd0, acc);
        chk({31'd0, acc}, 0, "R11 go refused busy");
        issue(2'd2, 2'd0, 4'hF, acc);
        chk({31'd0, acc}, 0, "R11 resume refused busy");
        bus_store('h104, 'h55);
        chk_flag(2, 0, "R6 GOING clears GO");
        chk({31'd0, busy}, 1, "R6 still busy");
        bus_store('h100, 0);
        chk({30'd0, busy, done}, 2'b10, "R7 bystander no end");
        bus_store('h100, 2);
        chk({29'd0, busy, done, exc}, 3'b010, "R7 done pulse");
        @(negedge clk);
        chk({31'd0, done}, 0, "R7 done one cycle");
    endtask

    task automatic t_progbuf_exc();
        logic acc;
        logic [31:0] d;
        issue(2'd1, 2'd0, 4'd0, acc);
        chk({31'd0, acc}, 1, "R4 accept progbuf");
        bus_load('h300, d); chk(d, 32'h0600006F, "R12 progbuf jal");
        @(negedge clk);
        bus_store('h10C, 0);
        chk({29'd0, busy, done, exc}, 3'b011, "R8 exception end");
        chk_flag(0, 0, "R8 GO cleared");
        @(negedge clk);
        chk({31'd0, exc}, 1, "R8 exc sticky");
    endtask

    task automatic t_resume();
        logic acc;
        logic [31:0] d;
        issue(2'd2, 2'd0, 4'hF, acc);
        chk({31'd0, acc}, 1, "R9 resume accept");
        chk({31'd0, exc}, 0, "R8 exc clears on accept");
        bus_load('h300, d); chk(d, 32'h5080006F, "R12 resume jal");
        @(negedge clk);
        chk({30'd0, busy, done}, 2'b01, "R9 resume done");
        chk_flag(0, 2, "R9 RESUME hart0");
        chk_flag(2, 2, "R9 RESUME hart2");
        chk_flag(1, 0, "R9 skip non-halted 1");
        chk_flag(3, 0, "R9 skip non-halted 3");
        bus_store('h108, 9);
        chk_flag(0, 2, "R10 out-of-range ignored flag");
        chk({28'd0, halted}, 4'b0101, "R10 out-of-range ignored halted");
        bus_store('h108, 0);
        chk_flag(0, 0, "R10 RESUME cleared");
        chk_flag(2, 2, "R10 other kept");
        chk({28'd0, halted}, 4'b0100, "R10 running");
        bus_store('h108, 2);
        chk({28'd0, halted}, 0, "R10 all running");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_halted();
        t_refuse_not_halted();
        t_abstract();
        t_progbuf_exc();
        t_resume();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule